// File: doc/BRIEF.md
# Supply-Guarded Memory Bus Gate

This block sits between an asynchronous static-memory control bus and the memory array behind it. The bus has three active-low controls: chip select, output enable and write enable. The block samples them into the local clock domain and decodes them into an internal read strobe, an internal write strobe and an enable for the data-bus drivers. Two digital supply flags come from the analog monitors. One says the supply is below the power-fail trip point. The other says it is below the battery switchover level.

While the supply is bad, every access is refused: the strobes and the data driver enable are all forced low. A write that is in progress when the fault arrives is cut off on the next clock. After the supply recovers, the block keeps the bus locked out for a fixed number of clock cycles, set by a parameter. A reset counts as a supply recovery. A further fault during the lock-out restarts the count. A separate battery-select output follows the switchover flag.

The supply flags are taken to be synchronous to the clock. The bus controls are asynchronous and pass through a two-stage synchronizer before they are decoded.

Top module: `pf_sram_gate`

## Requirements
- R1: While reset is asserted, all four outputs are 0. After reset is released, the bus stays locked out for REC_CYCLES clock edges, exactly as if the supply had just recovered.
- R2: When the synchronized chip select is high (1 = deselected), the next output update has the read strobe, the write strobe and the driver enable all at 0.
- R3: The write strobe is 1 exactly when chip select is 0 and write enable is 0 and access is allowed. It therefore rises when the later of the two controls falls and drops when the earlier of the two rises.
- R4: The read strobe is 1 when chip select is 0, write enable is 1 and access is allowed. The driver enable is 1 only when, in addition, output enable is 0. With output enable at 1 the data bus stays undriven.
- R5: When write enable goes to 0, the driver enable drops at the same update. If chip select and write enable fall together, the driver enable never becomes 1.
- R6: On any clock edge at which the power-fail flag is 1, the outputs registered at that edge have both strobes and the driver enable at 0, whatever the bus controls are. This includes cutting off a write that is in progress.
- R7: Access is refused on the first REC_CYCLES clock edges at which the power-fail flag is 0 after it was last 1. A power-fail flag of 1 during that window restarts the full count.
- R8: The battery-select output equals the switchover flag as sampled on the previous clock edge. It is 1 below the switchover level and 0 above it.
- R9: A change on a bus control pin reaches the strobes and the driver enable on the third rising clock edge after it, through two synchronizer stages plus the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Chip select from the bus, active low, asynchronous |
| bus_oe_n | input | 1 | Output enable from the bus, active low, asynchronous |
| bus_we_n | input | 1 | Write enable from the bus, active low, asynchronous |
| sup_fail | input | 1 | 1 while the supply is below the power-fail trip point (synchronous) |
| sup_batt | input | 1 | 1 while the supply is below the battery switchover level (synchronous) |
| arr_rd | output | 1 | Read strobe to the array |
| arr_wr | output | 1 | Write strobe to the array |
| dq_drive | output | 1 | Enable for the data bus output drivers |
| batt_sel | output | 1 | Selects the battery as the retention supply |

## Verification
The assertions assume that both supply flags change only between clock edges. They also assume the bus controls are stable enough that the synchronized copy reflects a real level for at least one cycle. The bench drives every input on the falling clock edge, so the supply flags are synchronous by construction and no bus control changes near a sampling edge. The recovery checks further assume REC_CYCLES is at least 1. The bench uses a short window so that both a full lock-out and a restarted lock-out fit into the run.

// File: rtl/pf_gate_pkg.sv
package pf_gate_pkg;
  localparam int BUS_W = 3;

  typedef struct packed {
    logic cs_n;
    logic oe_n;
    logic we_n;
  } bus_ctl_t;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_mode_e;

  localparam bus_ctl_t BUS_IDLE = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1};
endpackage

// File: rtl/pf_gate_sync.sv
module pf_gate_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= d_async;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/pf_gate_supply.sv
module pf_gate_supply #(
  parameter int REC_CYCLES = 5_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_fail,
  input  logic sup_batt,
  output logic access_ok,
  output logic batt_sel
);
  localparam int CW = $clog2(REC_CYCLES + 1);
  localparam logic [CW-1:0] REC_LOAD = CW'(REC_CYCLES);

  logic [CW-1:0] rec_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               rec_cnt <= REC_LOAD;
    else if (sup_fail)        rec_cnt <= REC_LOAD;
    else if (rec_cnt != '0)   rec_cnt <= rec_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) batt_sel <= 1'b0;
    else        batt_sel <= sup_batt;
  end

  assign access_ok = !sup_fail && (rec_cnt == '0);

  // R7
  rec_count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sup_fail && rec_cnt != '0) |=> (rec_cnt == $past(rec_cnt) - 1'b1));

  // R7
  rec_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sup_fail |=> (rec_cnt == REC_LOAD));
endmodule

// File: rtl/pf_gate_decode.sv
module pf_gate_decode
  import pf_gate_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  bus_ctl_t ctl,
  input  logic     access_ok,
  output logic     arr_rd,
  output logic     arr_wr,
  output logic     dq_drive
);
  acc_mode_e mode;

  always_comb begin
    mode = ACC_NONE;
    if (access_ok && !ctl.cs_n) begin
      if (!ctl.we_n) mode = ACC_WRITE;
      else           mode = ACC_READ;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_rd   <= 1'b0;
      arr_wr   <= 1'b0;
      dq_drive <= 1'b0;
    end else begin
      arr_rd   <= (mode == ACC_READ);
      arr_wr   <= (mode == ACC_WRITE);
      dq_drive <= (mode == ACC_READ) && !ctl.oe_n;
    end
  end

  // R2
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.cs_n |=> (!arr_rd && !arr_wr && !dq_drive));

  // R5
  we_kills_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.we_n |=> !dq_drive);

  // R4
  oe_high_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.oe_n |=> !dq_drive);
endmodule

// File: rtl/pf_sram_gate.sv
module pf_sram_gate
  import pf_gate_pkg::*;
#(
  parameter int REC_CYCLES  = 5_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_cs_n,
  input  logic bus_oe_n,
  input  logic bus_we_n,
  input  logic sup_fail,
  input  logic sup_batt,
  output logic arr_rd,
  output logic arr_wr,
  output logic dq_drive,
  output logic batt_sel
);
  bus_ctl_t raw_ctl;
  bus_ctl_t sync_ctl;
  logic     access_ok;

  assign raw_ctl = '{cs_n: bus_cs_n, oe_n: bus_oe_n, we_n: bus_we_n};

  pf_gate_sync #(
    .WIDTH  (BUS_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(BUS_IDLE)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(raw_ctl),
    .q_sync (sync_ctl)
  );

  pf_gate_supply #(
    .REC_CYCLES(REC_CYCLES)
  ) u_supply (
    .clk      (clk),
    .rst_n    (rst_n),
    .sup_fail (sup_fail),
    .sup_batt (sup_batt),
    .access_ok(access_ok),
    .batt_sel (batt_sel)
  );

  pf_gate_decode u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (sync_ctl),
    .access_ok(access_ok),
    .arr_rd   (arr_rd),
    .arr_wr   (arr_wr),
    .dq_drive (dq_drive)
  );

  // R6
  fail_blocks_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sup_fail |=> (!arr_rd && !arr_wr && !dq_drive));

  // R8
  batt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (batt_sel == $past(sup_batt)));

  // R3
  rd_wr_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr |-> (!arr_rd && !dq_drive));
endmodule

// File: tb/tb_pf_sram_gate.sv
module tb_pf_sram_gate;
  localparam int REC = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic s_fail = 1'b1, s_batt = 1'b1;
  logic arr_rd, arr_wr, dq_drive, batt_sel;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pf_sram_gate #(.REC_CYCLES(REC)) dut (
    .clk(clk), .rst_n(rst_n),
    .bus_cs_n(cs_n), .bus_oe_n(oe_n), .bus_we_n(we_n),
    .sup_fail(s_fail), .sup_batt(s_batt),
    .arr_rd(arr_rd), .arr_wr(arr_wr), .dq_drive(dq_drive), .batt_sel(batt_sel)
  );

  // Reference model: bus samples delayed by two edges, recovery as an integer
  logic [2:0] hist[$];
  int  rem;
  bit  e_rd, e_wr, e_dq, e_batt;
  string why;

  task automatic chk(input string tag, input bit act, input bit exp, input string sig);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b at cycle %0d", tag, sig, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      hist = '{3'b111, 3'b111};
      rem = REC;
      e_rd = 0; e_wr = 0; e_dq = 0; e_batt = 0;
      why = "R1";
    end else begin
      logic [2:0] d;
      bit ok;
      d = hist[0];
      void'(hist.pop_front());
      hist.push_back({cs_n, oe_n, we_n});
      ok = !s_fail && rem == 0;
      if (s_fail) why = "R6";
      else if (rem != 0) why = "R7";
      else if (d[2]) why = "R2";
      else if (!d[0]) why = "R3/R5";
      else why = "R4/R9";
      if (s_fail) rem = REC;
      else if (rem > 0) rem--;
      e_wr = ok && !d[2] && !d[0];
      e_rd = ok && !d[2] && d[0];
      e_dq = e_rd && !d[1];
      e_batt = s_batt;
    end
    #2;
    if (!done) begin
      chk(why, arr_wr, e_wr, "arr_wr");
      chk(why, arr_rd, e_rd, "arr_rd");
      chk(why, dq_drive, e_dq, "dq_drive");
      chk("R8", batt_sel, e_batt, "batt_sel");
    end
  end

  task automatic drv(input bit c, input bit o, input bit w, input int n);
    @(negedge clk);
    cs_n = c; oe_n = o; we_n = w;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic pwr(input bit f, input bit b);
    @(negedge clk);
    s_fail = f; s_batt = b;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: supply already good; read requested during post-reset lock-out
    pwr(0, 0);
    drv(0, 0, 1, REC + 8);
    // R9: deselect then a single read edge
    drv(1, 1, 1, 5);
    drv(0, 0, 1, 5);
    // R5: write enable falls during a driven read
    drv(0, 0, 0, 4);
    drv(0, 0, 1, 4);
    // R5: chip select and write enable fall together
    drv(1, 0, 1, 4);
    drv(0, 0, 0, 4);
    // R3: write controlled by chip select
    drv(1, 1, 0, 4);
    drv(0, 1, 0, 3);
    drv(1, 1, 0, 4);
    // R4: read with output enable toggling
    drv(0, 1, 1, 4);
    drv(0, 0, 1, 3);
    drv(0, 1, 1, 3);
    // R6: power fail cuts a write in progress, batt switch on deeper drop
    drv(0, 1, 0, 3);
    pwr(1, 0);
    drv(0, 1, 0, 3);
    pwr(1, 1);
    drv(0, 1, 0, 4);
    pwr(1, 0);
    pwr(0, 0);
    // R7: fault mid-recovery restarts the count
    drv(0, 1, 0, REC / 2);
    pwr(1, 0);
    pwr(0, 0);
    drv(0, 1, 0, REC + 6);
    // R2 and mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [4:0] r;
      r = 5'($urandom);
      @(negedge clk);
      cs_n = r[0] & r[3];
      oe_n = r[1];
      we_n = r[2];
      if (i % 97 == 50) s_fail = 1'b1;
      else if (i % 97 == 53) s_fail = 1'b0;
      s_batt = (i % 131 > 120);
    end
    drv(1, 1, 1, 5);
    finish_run();
  end

  initial begin
    wait (cycles > 150000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule